// File: doc/BRIEF.md
# Variable-Length Message Receive FIFO

This block buffers received bus messages whose size depends on their own header, inside one shared circular byte store of 64 bytes. A receive engine pushes a message one byte at a time: first a header byte, then the identifier bytes, then the payload bytes. It then pulses either a commit strobe, which keeps the message, or an abort strobe, which discards whatever was pushed. A message is kept only when the whole of it fits in the free space. A message that does not fit is dropped, but it still counts as pending, and the overrun output goes high.

On the CPU side, the oldest kept message is visible through a 13-byte addressed read window. A release strobe retires the head message, reuses its bytes and moves the window on to the next message. Once no kept messages are waiting, each further release retires one dropped message. A receive-pending output stays high while any message, kept or dropped, is waiting.

Top module: `msg_rx_fifo`

## Requirements
- R1: The byte store holds 64 bytes, shared by all kept messages, and the bytes in use never exceed 64.
- R2: The stored length of a message is taken from its header byte. Bit 7 set means extended format (4 identifier bytes), bit 7 clear means standard format (2 identifier bytes). Bit 6 set means a remote frame with no payload. Bits 3:0 give the payload count, and values above 8 count as 8. Length = 1 + identifier bytes + payload bytes, so it runs from 3 to 13.
- R3: A commit whose message length exceeds the free bytes drops that message and sets the overrun output in the next cycle.
- R4: Every further message that does not fit is also dropped. Once releases have freed enough bytes, a message that fits is kept.
- R5: Window address k (0 to 12) returns byte k of the oldest kept message, where byte 0 is the header. The content stays unchanged until a release.
- R6: A release retires the oldest kept message, frees its bytes and shows the next kept message in the window, including across the wrap of the store.
- R7: The pending count equals the kept messages plus the dropped messages not yet released. The receive-pending output is high exactly while this count is nonzero.
- R8: Window addresses at or beyond the head message's length, and every address while no kept message exists, read 0x00.
- R9: A release while the pending count is zero has no effect. While only dropped messages remain, each release removes one of them and leaves the read position unchanged. Kept messages are always released before dropped ones.
- R10: An abort discards the bytes pushed since the last commit or abort. Pending count, free space and the next message's placement stay as if nothing had been pushed.
- R11: The overrun output stays high until the pending count returns to zero, then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Push one byte of the message being received |
| wrByte | input | 8 | Byte being pushed |
| wrCommit | input | 1 | Keep the message just pushed (if it fits) |
| wrAbort | input | 1 | Discard the message just pushed |
| relCmd | input | 1 | Release the oldest pending message |
| rdAddr | input | 4 | Read window byte address |
| rdData | output | 8 | Read window byte (combinational) |
| pendCount | output | 9 | Pending messages, kept plus dropped |
| rxPending | output | 1 | High while pendCount is nonzero |
| overrun | output | 1 | A message has been dropped since the count was last zero |

## Verification
Assertions check the following on every cycle:
- the used-byte bound;
- that a drop raises overrun and adds one to the pending count;
- that an idle release changes neither the count nor the read position;
- that an abort leaves the space and the write position alone;
- that the window reads zero when no kept message exists.

Only the bench's scenarios can show that the window content is correct byte for byte. They cover every combination of header format, remote bit and payload code, with the store wrapping many times. The same applies to the ordering of kept and dropped releases, and to acceptance resuming after space is freed.

// File: rtl/msgfifo_pkg.sv
package msgfifo_pkg;

  localparam int WIN_BYTES = 13;

  typedef struct packed {
    logic wrEn;
    logic headValid;
  } dpStrobe_t;

  function automatic logic [3:0] msgLen(input logic [7:0] hdr);
    logic [3:0] pay;
    logic [3:0] idBytes;
    pay = (hdr[3:0] > 4'd8) ? 4'd8 : hdr[3:0];
    if (hdr[6]) pay = 4'd0;
    idBytes = hdr[7] ? 4'd4 : 4'd2;
    return 4'd1 + idBytes + pay;
  endfunction

endpackage

// File: rtl/msgfifo_ctrl.sv
module msgfifo_ctrl
  import msgfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrByte,
  input  logic             wrCommit,
  input  logic             wrAbort,
  input  logic             relCmd,
  input  logic [7:0]       headHdr,
  output dpStrobe_t        strobe,
  output logic [AW-1:0]    wrAddr,
  output logic [AW-1:0]    rdPtr,
  output logic [3:0]       headLen,
  output logic [CNT_W:0]   pendCount,
  output logic             overrun
);

  logic [AW-1:0]  wrPtr;
  logic [AW:0]    usedBytes;
  logic [AW:0]    freeBytes;
  logic [3:0]     wrOff;
  logic [7:0]     hdrCur;
  logic [3:0]     curLen;
  logic [CNT_W-1:0] validCnt, lostCnt, lostNext, validNext;
  logic           byteTake, fits, acceptMsg, dropMsg, relValid, relLost;

  assign freeBytes = (AW+1)'(DEPTH) - usedBytes;
  assign byteTake  = wrValid && !wrCommit && !wrAbort && (wrOff < 4'(WIN_BYTES));
  assign curLen    = msgLen(hdrCur);
  assign fits      = (AW+1)'(curLen) <= freeBytes;
  assign acceptMsg = wrCommit && fits;
  assign dropMsg   = wrCommit && !fits;
  assign headLen   = msgLen(headHdr);
  assign relValid  = relCmd && (validCnt != '0);
  assign relLost   = relCmd && (validCnt == '0) && (lostCnt != '0);

  assign strobe.wrEn      = byteTake && ((AW+1)'(wrOff) < freeBytes);
  assign strobe.headValid = (validCnt != '0);
  assign wrAddr           = wrPtr + AW'(wrOff);
  assign pendCount        = {1'b0, validCnt} + {1'b0, lostCnt};

  always_comb begin
    validNext = validCnt + CNT_W'(acceptMsg) - CNT_W'(relValid);
    lostNext  = lostCnt;
    if (dropMsg && (lostCnt != '1)) lostNext = lostNext + 1'b1;
    if (relLost) lostNext = lostNext - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      usedBytes <= '0;
      wrOff     <= '0;
      hdrCur    <= '0;
      validCnt  <= '0;
      lostCnt   <= '0;
      overrun   <= 1'b0;
    end else begin
      if (wrCommit || wrAbort) begin
        wrOff <= '0;
      end else if (byteTake) begin
        wrOff <= wrOff + 1'b1;
        if (wrOff == '0) hdrCur <= wrByte;
      end
      if (acceptMsg) wrPtr <= wrPtr + AW'(curLen);
      if (relValid)  rdPtr <= rdPtr + AW'(headLen);
      usedBytes <= usedBytes + (acceptMsg ? (AW+1)'(curLen) : '0)
                             - (relValid ? (AW+1)'(headLen) : '0);
      validCnt <= validNext;
      lostCnt  <= lostNext;
      if (dropMsg) overrun <= 1'b1;
      else if ((validNext == '0) && (lostNext == '0)) overrun <= 1'b0;
    end
  end

  // R1: bytes in use never exceed the store
  assert_capacity_R1: assert property (@(posedge clk) disable iff (!rstN)
    usedBytes <= (AW+1)'(DEPTH));

  // R3: a drop raises the overrun output
  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    dropMsg |=> overrun);

  // R7: a drop still adds a pending message
  assert_drop_counts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dropMsg && !relCmd && (lostCnt != '1)) |=> pendCount == $past(pendCount) + 1'b1);

  // R9: an idle release changes nothing
  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (relCmd && (pendCount == '0) && !wrCommit) |=> (pendCount == '0) && $stable(rdPtr));

  // R10: an abort leaves space and placement alone
  assert_abort_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrAbort && !wrCommit && !relCmd) |=> $stable(usedBytes) && $stable(wrPtr));

endmodule

// File: rtl/msgfifo_data.sv
module msgfifo_data
  import msgfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrByte,
  input  logic [AW-1:0] rdPtr,
  input  logic [3:0]    headLen,
  input  logic [3:0]    rdAddr,
  output logic [7:0]    headHdr,
  output logic [7:0]    rdData
);

  logic [7:0]    store [DEPTH];
  logic [AW-1:0] winAddr;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrAddr] <= wrByte;
  end

  assign headHdr = store[rdPtr];
  assign winAddr = rdPtr + AW'(rdAddr);
  assign rdData  = (strobe.headValid && (rdAddr < headLen)) ? store[winAddr] : 8'h00;

  // R8: window reads zero with no kept message
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.headValid |-> (rdData == 8'h00));

endmodule

// File: rtl/msg_rx_fifo.sv
module msg_rx_fifo
  import msgfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [7:0]       wrByte,
  input  logic             wrCommit,
  input  logic             wrAbort,
  input  logic             relCmd,
  input  logic [3:0]       rdAddr,
  output logic [7:0]       rdData,
  output logic [CNT_W:0]   pendCount,
  output logic             rxPending,
  output logic             overrun
);

  dpStrobe_t     strobe;
  logic [AW-1:0] wrAddr, rdPtr;
  logic [3:0]    headLen;
  logic [7:0]    headHdr;

  msgfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte),
    .wrCommit(wrCommit), .wrAbort(wrAbort), .relCmd(relCmd),
    .headHdr(headHdr), .strobe(strobe), .wrAddr(wrAddr), .rdPtr(rdPtr),
    .headLen(headLen), .pendCount(pendCount), .overrun(overrun)
  );

  msgfifo_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrByte(wrByte),
    .rdPtr(rdPtr), .headLen(headLen), .rdAddr(rdAddr),
    .headHdr(headHdr), .rdData(rdData)
  );

  assign rxPending = (pendCount != '0);

endmodule

// File: tb/tb_msg_rx_fifo.sv
module tb_msg_rx_fifo;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0, wrCommit = 1'b0, wrAbort = 1'b0, relCmd = 1'b0;
  logic [7:0] wrByte = '0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [8:0] pendCount;
  logic       rxPending, overrun;

  int checks = 0;
  int fails = 0;
  int mBytes[$];
  int mLens[$];
  int mLost = 0;
  bit mOvf = 0;

  always #10 clk = ~clk;

  msg_rx_fifo dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte),
    .wrCommit(wrCommit), .wrAbort(wrAbort), .relCmd(relCmd),
    .rdAddr(rdAddr), .rdData(rdData), .pendCount(pendCount),
    .rxPending(rxPending), .overrun(overrun)
  );

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #2;
  endtask

  function automatic int lenOf(int hdr);
    int pay = hdr & 15;
    if (pay > 8) pay = 8;
    if ((hdr & 64) != 0) pay = 0;
    return 1 + (((hdr & 128) != 0) ? 4 : 2) + pay;
  endfunction

  function automatic int byteAt(int hdr, int seed, int i);
    return (i == 0) ? hdr : ((seed * 29 + i * 11 + 5) & 255);
  endfunction

  // R2, R3, R4: push a whole message then commit; model keeps or drops it
  task automatic sendMsg(int hdr, int seed);
    int len = lenOf(hdr);
    int used = mBytes.size();
    for (int i = 0; i < len; i++) begin
      wrValid = 1'b1; wrByte = 8'(byteAt(hdr, seed, i));
      step();
    end
    wrValid = 1'b0;
    wrCommit = 1'b1;
    step();
    wrCommit = 1'b0;
    if (len <= 64 - used) begin
      for (int i = 0; i < len; i++) mBytes.push_back(byteAt(hdr, seed, i));
      mLens.push_back(len);
    end else begin
      mLost++;
      mOvf = 1;
    end
  endtask

  // R6, R9: release, kept first then dropped
  task automatic relMsg;
    relCmd = 1'b1;
    step();
    relCmd = 1'b0;
    if (mLens.size() > 0) begin
      int l = mLens.pop_front();
      for (int i = 0; i < l; i++) void'(mBytes.pop_front());
    end else if (mLost > 0) begin
      mLost--;
    end
    if (mLens.size() == 0 && mLost == 0) mOvf = 0;
  endtask

  task automatic checkAll(string tag);
    int pend = mLens.size() + mLost;
    chk({tag, " R7 count"}, int'(pendCount), pend);
    chk({tag, " R7 pending"}, int'(rxPending), (pend != 0) ? 1 : 0);
    chk({tag, " R3/R11 overrun"}, int'(overrun), int'(mOvf));
    for (int a = 0; a < 16; a++) begin
      int exp;
      bit inside_msg;
      inside_msg = (mLens.size() > 0) && (a < mLens[0]);
      exp = inside_msg ? mBytes[a] : 0;
      rdAddr = 4'(a);
      #1;
      chk({tag, inside_msg ? " R5 window" : " R8 window"}, int'(rdData), exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    step();
    checkAll("reset R8");

    // R9: release with nothing pending
    relMsg();
    checkAll("idle release R9");

    // R2, R6: every header combination, store wraps many times
    for (int ext = 0; ext < 2; ext++)
      for (int rtr = 0; rtr < 2; rtr++)
        for (int dlc = 0; dlc < 16; dlc++) begin
          int hdr = ext * 128 + rtr * 64 + dlc;
          sendMsg(hdr, hdr + 3);
          checkAll("sweep R2");
          relMsg();
          checkAll("sweep release R6");
        end

    // R6: several queued messages of mixed length, drained in order
    for (int k = 0; k < 5; k++) sendMsg((k % 2) * 128 + k + 2, 40 + k);
    checkAll("queued R5");
    for (int k = 0; k < 5; k++) begin
      relMsg();
      checkAll("queued release R6");
    end

    // R1, R3, R4: fill with 13-byte messages until drops
    for (int k = 0; k < 4; k++) sendMsg(128 + 8, 70 + k);
    checkAll("fill R1");
    sendMsg(128 + 8, 80);
    checkAll("first drop R3");
    sendMsg(128 + 15, 81);
    checkAll("second drop R4");
    sendMsg(64 + 3, 82);
    checkAll("small fits R4");
    relMsg();
    checkAll("after free R6");
    sendMsg(128 + 8, 83);
    checkAll("room again R4");
    sendMsg(128 + 8, 84);
    checkAll("drop again R4");
    // drain kept first, then dropped ones one per release
    while (mLens.size() + mLost > 0) begin
      relMsg();
      checkAll("drain R9 R11");
    end
    sendMsg(7, 90);
    checkAll("after drain R9");
    relMsg();
    checkAll("after drain release R6");

    // R10: abort part-way, then a fresh message lands cleanly
    for (int i = 0; i < 4; i++) begin
      wrValid = 1'b1; wrByte = 8'(200 + i);
      step();
    end
    wrValid = 1'b0;
    wrAbort = 1'b1;
    step();
    wrAbort = 1'b0;
    checkAll("abort R10");
    sendMsg(128 + 5, 95);
    checkAll("after abort R10");
    relMsg();
    checkAll("after abort release R10");

    summary();
  end

endmodule